// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block takes the commands of a serial flash slave on an SPI link in mode 0 and decides whether each one may run. It collects opcode and address bits while chip select is low and holds the status byte. That byte carries a busy flag, a write enable latch, a three-bit protected-region code and a lock bit. When chip select rises, the block either fires a one-cycle execute strobe for a program, sector erase, bulk erase or status write, or it pulses a reject strobe. A down-counter stands in for the time the array needs, and a power-up timer keeps every modifying command out for a fixed time after reset.

The SPI pins are sampled with the system clock, so the serial clock must run at well under a quarter of the system clock. Array, charge pumps and program data are outside the block. Only the strobes, the captured address and the serial status readback leave it.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 00h. Opcode 06h with exactly 8 clocks sets the write enable latch (status bit 1). Opcode 04h with exactly 8 clocks clears it.
- R2: Opcode 05h returns the status byte on `spiMiso`, MSB first, changing after each falling serial clock edge. The byte repeats every 8 further clocks. Layout: bit 0 busy, bit 1 write enable latch, bits 4:2 region code, bit 7 lock bit, bits 6:5 zero.
- R3: Page program (02h), sector erase (D8h), bulk erase (C7h) and status write (01h) run only while the write enable latch is set. Otherwise `cmdReject` pulses and no execute strobe fires.
- R4: Clock counts at deselect must be exactly 32 for sector erase, exactly 8 for bulk erase, exactly 16 for status write, and at least 40 and a multiple of 8 for page program. Any other count rejects the command and changes no state.
- R5: With region code k in 1..6, sectors whose top 7-k index bits (the top 8 of the 24-bit address by default) are all ones are protected. Code 7 protects every sector and code 0 protects none. Program or sector erase aimed at a protected sector is rejected. Bulk erase is rejected whenever the code is not 0.
- R6: A status write is rejected while the lock bit is 1 and `wpN` is low. An accepted status write loads the region code from data bits 4:2 and the lock bit from data bit 7.
- R7: For the first PWRUP_CYCLES clocks after reset every modifying command is rejected. The enable and disable opcodes still act.
- R8: An accepted command gives exactly one execute strobe, one clock after chip select rises, with `exeAddr` holding the 24 address bits. The busy flag then stays set for OP_CYCLES clocks, and its end clears both busy and the write enable latch. At most one of the four execute strobes and `cmdReject` is high in any cycle.
- R9: While busy is set, only read status acts. Enable and disable have no effect. Modifying commands pulse `cmdReject` and do not run.
- R10: `standby` is high only while chip select is high and busy is clear. Raising chip select does not end a running operation.
- R11: Read status and unknown opcodes change no state and give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| spiSclk | input | 1 | Serial clock, idle low |
| spiCsN | input | 1 | Chip select, active low |
| spiMosi | input | 1 | Serial data in |
| spiMiso | output | 1 | Serial data out (status readback) |
| wpN | input | 1 | Write-protect pin, active low |
| exeProg | output | 1 | Page program execute strobe |
| exeSectErase | output | 1 | Sector erase execute strobe |
| exeBulkErase | output | 1 | Bulk erase execute strobe |
| exeStatusWr | output | 1 | Status write execute strobe |
| exeAddr | output | 24 | Address captured from the command |
| cmdReject | output | 1 | Modifying command refused |
| standby | output | 1 | Deselected and idle |

## Verification
The bench builds the block with PWRUP_CYCLES = 600 and OP_CYCLES = 500. These are short enough that the power-up window and many complete busy periods fit in one run. The busy period is still long enough for a status read, a disable and a refused bulk erase to be issued while one sector erase is running. The default 8-bit sector index is kept, so a region code of 1 protects only sectors FCh..FFh, and the boundary between sector FBh and sector FCh can be hit directly.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [7:0] {
    OP_WREN = 8'h06,
    OP_WRDI = 8'h04,
    OP_RDSR = 8'h05,
    OP_WRSR = 8'h01,
    OP_PP   = 8'h02,
    OP_SE   = 8'hD8,
    OP_BE   = 8'hC7
  } opcode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic wrStatus;
    logic setWip;
    logic clrWip;
  } ctrlStb_t;

endpackage

// File: rtl/flash_wp_datapath.sv
module flash_wp_datapath
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SECT_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  input  ctrlStb_t          stb,
  output logic              miso,
  output logic              csRise,
  output logic [7:0]        opcode,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [ADDR_W-1:0] addr,
  output logic              protHit,
  output logic [2:0]        bp,
  output logic              srwd,
  output logic              wel,
  output logic              wip
);
  localparam int ADDR_END = 8 + ADDR_W;

  logic sclkQ, csQ;
  logic sclkRise, sclkFall, csFall;
  logic [7:0] shiftReg;
  logic [7:0] statusByte;
  logic [SECT_W-1:0] sector;
  logic [2:0] kLen;

  assign sclkRise = sclk & ~sclkQ & ~csN;
  assign sclkFall = ~sclk & sclkQ & ~csN;
  assign csFall   = ~csN & csQ;
  assign csRise   = csN & ~csQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
    end
  end

  // command shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      opcode   <= '0;
      addr     <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
      opcode <= '0;
    end else if (sclkRise) begin
      if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      shiftReg <= {shiftReg[6:0], mosi};
      if (bitCnt == CNT_W'(7)) opcode <= {shiftReg[6:0], mosi};
      if (bitCnt >= CNT_W'(8) && bitCnt < CNT_W'(ADDR_END))
        addr <= {addr[ADDR_W-2:0], mosi};
    end
  end

  // status register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel  <= 1'b0;
      wip  <= 1'b0;
      bp   <= 3'd0;
      srwd <= 1'b0;
    end else begin
      if (stb.clrWel)      wel <= 1'b0;
      else if (stb.setWel) wel <= 1'b1;
      if (stb.clrWip)      wip <= 1'b0;
      else if (stb.setWip) wip <= 1'b1;
      if (stb.wrStatus) begin
        bp   <= shiftReg[4:2];
        srwd <= shiftReg[7];
      end
    end
  end

  assign statusByte = {srwd, 2'b00, bp, wel, wip};

  // status readback, MSB first, changing on falling serial clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) miso <= 1'b0;
    else if (csN) miso <= 1'b0;
    else if (sclkFall)
      miso <= (opcode == OP_RDSR) ? statusByte[3'd7 - bitCnt[2:0]] : 1'b0;
  end

  // protected region: top (7-bp) sector bits all ones
  assign sector = addr[ADDR_W-1 -: SECT_W];
  always_comb begin
    kLen    = 3'd7 - bp;
    protHit = (bp != 3'd0);
    for (int i = 0; i < 6; i++) begin
      if (i < int'(kLen)) protHit = protHit & sector[SECT_W-1-i];
    end
  end

endmodule

// File: rtl/flash_wp_control.sv
module flash_wp_control
  import flash_wp_pkg::*;
#(
  parameter int PWRUP_CYCLES = 4000,
  parameter int OP_CYCLES    = 2000,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csRise,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             protHit,
  input  logic [2:0]       bp,
  input  logic             srwd,
  input  logic             wel,
  input  logic             wip,
  input  logic             wpN,
  output ctrlStb_t         stb,
  output logic             pwrDone,
  output logic             exeProg,
  output logic             exeSectErase,
  output logic             exeBulkErase,
  output logic             exeStatusWr,
  output logic             cmdReject
);
  localparam int PW_W = $clog2(PWRUP_CYCLES + 1);
  localparam int OP_W = $clog2(OP_CYCLES + 1);

  logic [PW_W-1:0] pwrCnt;
  logic [OP_W-1:0] busyCnt;
  logic isPp, isSe, isBe, isWrsr, isMod;
  logic lenOk, blocked, accept, opDone, idleEnd;

  assign pwrDone = (pwrCnt == PW_W'(PWRUP_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrCnt <= '0;
    else if (!pwrDone) pwrCnt <= pwrCnt + 1'b1;
  end

  assign isPp   = (opcode == OP_PP);
  assign isSe   = (opcode == OP_SE);
  assign isBe   = (opcode == OP_BE);
  assign isWrsr = (opcode == OP_WRSR);
  assign isMod  = isPp | isSe | isBe | isWrsr;

  always_comb begin
    lenOk   = 1'b0;
    blocked = 1'b0;
    if (isPp) begin
      lenOk   = (bitCnt >= CNT_W'(40)) && (bitCnt[2:0] == 3'd0);
      blocked = protHit;
    end else if (isSe) begin
      lenOk   = (bitCnt == CNT_W'(32));
      blocked = protHit;
    end else if (isBe) begin
      lenOk   = (bitCnt == CNT_W'(8));
      blocked = (bp != 3'd0);
    end else if (isWrsr) begin
      lenOk   = (bitCnt == CNT_W'(16));
      blocked = srwd & ~wpN;
    end
  end

  assign idleEnd = csRise & ~wip;
  assign accept  = idleEnd & pwrDone & wel & isMod & lenOk & ~blocked;
  assign opDone  = wip & (busyCnt == OP_W'(1));

  always_comb begin
    stb.setWel   = idleEnd & (opcode == OP_WREN) & (bitCnt == CNT_W'(8));
    stb.clrWel   = (idleEnd & (opcode == OP_WRDI) & (bitCnt == CNT_W'(8))) | opDone;
    stb.wrStatus = accept & isWrsr;
    stb.setWip   = accept;
    stb.clrWip   = opDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (accept) busyCnt <= OP_W'(OP_CYCLES);
    else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exeProg      <= 1'b0;
      exeSectErase <= 1'b0;
      exeBulkErase <= 1'b0;
      exeStatusWr  <= 1'b0;
      cmdReject    <= 1'b0;
    end else begin
      exeProg      <= accept & isPp;
      exeSectErase <= accept & isSe;
      exeBulkErase <= accept & isBe;
      exeStatusWr  <= accept & isWrsr;
      cmdReject    <= csRise & isMod & ~accept;
    end
  end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int SECT_W       = 8,
  parameter int CNT_W        = 12,
  parameter int PWRUP_CYCLES = 4000,
  parameter int OP_CYCLES    = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  input  logic              wpN,
  output logic              exeProg,
  output logic              exeSectErase,
  output logic              exeBulkErase,
  output logic              exeStatusWr,
  output logic [ADDR_W-1:0] exeAddr,
  output logic              cmdReject,
  output logic              standby
);
  ctrlStb_t stb;
  logic csRise, protHit, srwd, wel, wip, pwrDone;
  logic [7:0] opcode;
  logic [CNT_W-1:0] bitCnt;
  logic [2:0] bp;

  flash_wp_datapath #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CNT_W(CNT_W)) dpI (
    .clk(clk), .rstN(rstN), .sclk(spiSclk), .csN(spiCsN), .mosi(spiMosi),
    .stb(stb), .miso(spiMiso), .csRise(csRise), .opcode(opcode),
    .bitCnt(bitCnt), .addr(exeAddr), .protHit(protHit), .bp(bp),
    .srwd(srwd), .wel(wel), .wip(wip)
  );

  flash_wp_control #(.PWRUP_CYCLES(PWRUP_CYCLES), .OP_CYCLES(OP_CYCLES),
                     .CNT_W(CNT_W)) ctlI (
    .clk(clk), .rstN(rstN), .csRise(csRise), .opcode(opcode),
    .bitCnt(bitCnt), .protHit(protHit), .bp(bp), .srwd(srwd), .wel(wel),
    .wip(wip), .wpN(wpN), .stb(stb), .pwrDone(pwrDone), .exeProg(exeProg),
    .exeSectErase(exeSectErase), .exeBulkErase(exeBulkErase),
    .exeStatusWr(exeStatusWr), .cmdReject(cmdReject)
  );

  assign standby = spiCsN & ~wip;

endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wpN,
  input logic       exeProg,
  input logic       exeSectErase,
  input logic       exeBulkErase,
  input logic       exeStatusWr,
  input logic       cmdReject,
  input logic       welQ,
  input logic       wipQ,
  input logic [2:0] bpQ,
  input logic       srwdQ,
  input logic       pwrDone
);
  logic anyExe;
  assign anyExe = exeProg | exeSectErase | exeBulkErase | exeStatusWr;

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({exeProg, exeSectErase, exeBulkErase, exeStatusWr, cmdReject}));

  // R3
  exe_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyExe |-> $past(welQ));

  // R8
  exe_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyExe |-> wipQ);

  // R8
  busy_from_exe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wipQ) |-> anyExe);

  // R8
  done_clears_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wipQ) |-> !welQ);

  // R6
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    exeStatusWr |-> !$past(srwdQ && !wpN));

  // R5
  bulk_unprot_chk: assert property (@(posedge clk) disable iff (!rstN)
    exeBulkErase |-> ($past(bpQ) == 3'd0));

  // R7
  pwrup_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDone |-> !anyExe);

  // R9
  busy_no_exe_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyExe |-> !$past(wipQ));

endmodule

bind flash_wp_ctrl flash_wp_chk chkI (
  .clk(clk), .rstN(rstN), .wpN(wpN), .exeProg(exeProg),
  .exeSectErase(exeSectErase), .exeBulkErase(exeBulkErase),
  .exeStatusWr(exeStatusWr), .cmdReject(cmdReject), .welQ(wel),
  .wipQ(wip), .bpQ(bp), .srwdQ(srwd), .pwrDone(pwrDone)
);

// File: tb/tb_flash_wp_ctrl.sv
module tb_flash_wp_ctrl;
  localparam int PWRUP = 600;
  localparam int OPC   = 500;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0, wpN = 1'b1;
  logic miso, exeProg, exeSectErase, exeBulkErase, exeStatusWr, cmdReject, standby;
  logic [23:0] exeAddr;

  int nChk = 0, nFail = 0;
  int cProg = 0, cSect = 0, cBulk = 0, cStat = 0, cRej = 0;
  logic [23:0] lastAddr = '0;
  bit mWel = 0, mSrwd = 0, mPwr = 0, done = 0;
  logic [2:0] mBp = 3'd0;

  always #2.5 clk = ~clk;

  flash_wp_ctrl #(.PWRUP_CYCLES(PWRUP), .OP_CYCLES(OPC)) dut (
    .clk(clk), .rstN(rstN), .spiSclk(sclk), .spiCsN(csN), .spiMosi(mosi),
    .spiMiso(miso), .wpN(wpN), .exeProg(exeProg), .exeSectErase(exeSectErase),
    .exeBulkErase(exeBulkErase), .exeStatusWr(exeStatusWr), .exeAddr(exeAddr),
    .cmdReject(cmdReject), .standby(standby)
  );

  always @(negedge clk) begin
    if (exeProg) cProg++;
    if (exeSectErase) cSect++;
    if (exeBulkErase) cBulk++;
    if (exeStatusWr) cStat++;
    if (cmdReject) cRej++;
    if (exeProg | exeSectErase) lastAddr <= exeAddr;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  task automatic spiCmd(input logic [55:0] v, input int n, output logic [15:0] rd);
    rd = '0;
    @(negedge clk) csN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = v[55-i];
      repeat (2) @(negedge clk);
      if (i >= 8 && i < 24) rd[23-i] = miso;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit protExp(input logic [2:0] b, input logic [23:0] a);
    int thr;
    if (b == 3'd0) return 1'b0;
    if (b == 3'd7) return 1'b1;
    thr = 256 - (256 >> (7 - b));
    return int'(a[23:16]) >= thr;
  endfunction

  function automatic bit isModOp(input logic [7:0] op);
    return op == 8'h02 || op == 8'hD8 || op == 8'hC7 || op == 8'h01;
  endfunction

  function automatic bit expAccept(input logic [7:0] op, input int n, input logic [39:0] pay);
    bit lenOk, blk;
    case (op)
      8'h02: begin lenOk = (n >= 40) && (n % 8 == 0); blk = protExp(mBp, pay[39:16]); end
      8'hD8: begin lenOk = (n == 32); blk = protExp(mBp, pay[39:16]); end
      8'hC7: begin lenOk = (n == 8); blk = (mBp != 3'd0); end
      8'h01: begin lenOk = (n == 16); blk = mSrwd && !wpN; end
      default: return 1'b0;
    endcase
    return mPwr && mWel && lenOk && !blk;
  endfunction

  function automatic logic [7:0] expStat();
    return {mSrwd, 2'b00, mBp, mWel, 1'b0};
  endfunction

  task automatic readStat(input string req);
    logic [15:0] rd;
    spiCmd({8'h05, 48'h0}, 24, rd);
    check(rd[15:8] == expStat(), req, {24'h0, rd[15:8]}, {24'h0, expStat()});
    // R2: second byte repeats the first
    check(rd[7:0] == rd[15:8], "R2", {24'h0, rd[7:0]}, {24'h0, rd[15:8]});
  endtask

  task automatic doCmd(input logic [7:0] op, input logic [39:0] pay, input int n, input string req);
    logic [15:0] rd;
    int p0, s0, b0, w0, r0;
    bit acc;
    logic [4:0] expV, actV;
    p0 = cProg; s0 = cSect; b0 = cBulk; w0 = cStat; r0 = cRej;
    acc = expAccept(op, n, pay);
    spiCmd({op, pay, 8'h00}, n, rd);
    expV = {acc && op == 8'h02, acc && op == 8'hD8, acc && op == 8'hC7,
            acc && op == 8'h01, isModOp(op) && !acc};
    actV = {cProg != p0, cSect != s0, cBulk != b0, cStat != w0, cRej != r0};
    check(actV == expV && (cProg - p0) + (cSect - s0) + (cBulk - b0) + (cStat - w0) + (cRej - r0) == int'(isModOp(op)),
          req, {27'h0, actV}, {27'h0, expV});
    if (acc && (op == 8'h02 || op == 8'hD8))
      check(lastAddr == pay[39:16], "R8", {8'h0, lastAddr}, {8'h0, pay[39:16]});
    if (op == 8'h06 && n == 8) mWel = 1'b1;
    if (op == 8'h04 && n == 8) mWel = 1'b0;
    if (acc) begin
      if (op == 8'h01) begin mBp = pay[36:34]; mSrwd = pay[39]; end
      repeat (OPC + 5) @(negedge clk);
      mWel = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [15:0] rd;
    int p0, b0, r0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    check(standby == 1'b1 && miso == 1'b0, "R10", {30'h0, standby, miso}, 32'h2);
    check({exeProg, exeSectErase, exeBulkErase, exeStatusWr, cmdReject} == 5'd0, "R8",
          {27'h0, exeProg, exeSectErase, exeBulkErase, exeStatusWr, cmdReject}, 32'h0);
    readStat("R1");
    // R7: enable works, modifying refused during power-up
    doCmd(8'h06, 40'h0, 8, "R7");
    doCmd(8'hD8, 40'h000000_0000, 32, "R7");
    readStat("R7");
    repeat (PWRUP) @(negedge clk);
    mPwr = 1;
    // R1 enable/disable
    doCmd(8'h04, 40'h0, 8, "R1");
    readStat("R1");
    doCmd(8'h06, 40'h0, 8, "R1");
    readStat("R1");
    // R3 without latch
    doCmd(8'h04, 40'h0, 8, "R3");
    doCmd(8'hC7, 40'h0, 8, "R3");
    // R8 / R9 / R10 busy window
    doCmd(8'h06, 40'h0, 8, "R1");
    p0 = cSect;
    spiCmd({8'hD8, 24'h120000, 24'h0}, 32, rd);
    check(cSect - p0 == 1 && lastAddr == 24'h120000, "R8", {8'h0, lastAddr}, 32'h120000);
    check(standby == 1'b0, "R10", {31'h0, standby}, 32'h0);
    spiCmd({8'h05, 48'h0}, 24, rd);
    check(rd == 16'h0303, "R9", {16'h0, rd}, 32'h0303);
    spiCmd({8'h04, 48'h0}, 8, rd);
    spiCmd({8'h05, 48'h0}, 24, rd);
    check(rd[15:8] == 8'h03, "R9", {24'h0, rd[15:8]}, 32'h03);
    b0 = cBulk; r0 = cRej;
    spiCmd({8'hC7, 48'h0}, 8, rd);
    check(cBulk == b0 && cRej - r0 == 1, "R9", cBulk - b0, 32'h0);
    repeat (OPC) @(negedge clk);
    mWel = 0;
    check(standby == 1'b1, "R10", {31'h0, standby}, 32'h1);
    readStat("R8");
    // R5 software protection, boundary sector FC vs FB
    doCmd(8'h06, 40'h0, 8, "R6");
    doCmd(8'h01, {8'h04, 32'h0}, 16, "R6");
    readStat("R6");
    doCmd(8'h06, 40'h0, 8, "R5");
    doCmd(8'hD8, {24'hFC0000, 16'h0}, 32, "R5");
    doCmd(8'h02, {24'hFFFF00, 16'h0}, 40, "R5");
    doCmd(8'hC7, 40'h0, 8, "R5");
    doCmd(8'hD8, {24'hFB0000, 16'h0}, 32, "R5");
    // R6 hardware protection
    doCmd(8'h06, 40'h0, 8, "R6");
    doCmd(8'h01, {8'h84, 32'h0}, 16, "R6");
    wpN = 1'b0;
    doCmd(8'h06, 40'h0, 8, "R6");
    doCmd(8'h01, {8'h00, 32'h0}, 16, "R6");
    readStat("R6");
    wpN = 1'b1;
    doCmd(8'h01, {8'h00, 32'h0}, 16, "R6");
    readStat("R6");
    // R4 clock count
    doCmd(8'h06, 40'h0, 8, "R4");
    doCmd(8'hC7, 40'h0, 9, "R4");
    doCmd(8'h02, {24'h001000, 16'h0}, 44, "R4");
    readStat("R4");
    doCmd(8'hC7, 40'h0, 8, "R4");
    // R11 unknown opcode
    doCmd(8'h06, 40'h0, 8, "R11");
    doCmd(8'hAB, 40'h0, 8, "R11");
    readStat("R11");
    // constrained random
    for (int it = 0; it < 100; it++) begin
      logic [7:0] op;
      logic [39:0] pay;
      int sel, n, nom;
      sel = $urandom % 8;
      pay = {$urandom, 8'($urandom)};
      wpN = ($urandom % 4) != 0;
      case (sel)
        0: op = 8'h06; 1: op = 8'h04; 2: op = 8'h02; 3: op = 8'hD8;
        4: op = 8'hC7; 5: op = 8'h01; 6: op = 8'h05;
        default: begin
          op = 8'($urandom);
          if (isModOp(op) || op == 8'h06 || op == 8'h04) op = 8'hFF;
        end
      endcase
      case (op)
        8'h02: nom = ($urandom % 2) ? 48 : 40;
        8'hD8: nom = 32;
        8'h01: nom = 16;
        8'h05: nom = 24;
        default: nom = 8;
      endcase
      n = nom;
      if ($urandom % 4 == 0) n = nom + int'($urandom % 7) + 1;
      if (isModOp(op) && ($urandom % 10) < 7) doCmd(8'h06, 40'h0, 8, "R1");
      doCmd(op, pay, n, isModOp(op) ? "R3" : "R11");
      readStat("R2");
    end
    done = 1;
    summary();
  end

endmodule